// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block holds return addresses for a small instruction sequencer. When a subroutine call executes, the PC unit presents the already-incremented return address together with a save strobe. The block moves its newest entry one level deeper and stores the new address on top. When a return executes, a restore strobe moves the deeper entry up one level. The PC takes the top entry in that same cycle.

The stack is a chain of registers that shift and nothing more. It keeps no pointer and raises no flags. On overflow the oldest address is lost without any signal. On underflow the deepest level keeps supplying whatever it last held. The top entry comes straight from a register, so the PC can load it on the return cycle with no added logic in that path.

Top module: `rstk_top`

## Requirements
- R1: After a synchronous reset, every level holds zero, so `top_o` reads 0 on the first cycle after reset.
- R2: On a cycle with `push_i` high, `top_o` on the next cycle equals the `push_addr_i` that was sampled on that edge.
- R3: A push moves the former level-1 entry into level 2, so push A, push B, pop leaves `top_o` equal to A.
- R4: After three or more pushes in a row, only the two newest addresses remain. Push A, B, C followed by pops returns C, then B, then B.
- R5: On a cycle with only `pop_i` high, `top_o` on the next cycle equals the value level 2 held before that edge.
- R6: A pop leaves level 2 unchanged, so after it has been emptied, every further pop keeps returning the last address that was held in level 2.
- R7: When `push_i` and `pop_i` are high in the same cycle, the push takes effect and the pop is ignored.
- R8: On a cycle with neither strobe high, `top_o` and the hidden level keep their values. A later pop returns the same address it would have returned without the idle cycles.
- R9: Each level is `ADDR_W` bits wide, with 12 as the default. Address bits above bit 7 are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Save strobe from call execution |
| push_addr_i | input | ADDR_W | Return address to save (PC+1) |
| pop_i | input | 1 | Restore strobe from return execution |
| top_o | output | ADDR_W | Level-1 entry, the PC value on a return |

## Verification
The assertions assume that `push_i` and `pop_i` are defined on every clock edge once reset is released. They also assume that a combined push and pop means a push. Under those conditions, every edge has a fully determined effect on both levels. The stimulus draws its strobes from a fixed seed and fills the address with values that use the upper bits. It includes idle cycles and some cycles with both strobes high. Directed runs of three pushes and three pops are added to reach the overflow and underflow shifts.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  // Operation applied to the level chain on one clock edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
  import rstk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);
  // Push outranks pop when both strobes arrive together.
  always_comb begin
    if (push_i)     op_o = OP_PUSH;
    else if (pop_i) op_o = OP_POP;
    else            op_o = OP_HOLD;
  end
endmodule

// File: rtl/rstk_level.sv
module rstk_level
  import rstk_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op_i,
  input  logic [ADDR_W-1:0] from_above_i,
  input  logic [ADDR_W-1:0] from_below_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: q_o <= from_above_i;
        OP_POP:  q_o <= from_below_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/rstk_top.sv
module rstk_top
  import rstk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] top_o
);
  localparam int LAST = DEPTH - 1;

  stk_op_e op;
  logic [ADDR_W-1:0] lvl_q [DEPTH];

  rstk_decode u_decode (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [ADDR_W-1:0] above;
    logic [ADDR_W-1:0] below;
    if (i == 0) begin : g_head
      assign above = push_addr_i;
    end else begin : g_body
      assign above = lvl_q[i-1];
    end
    if (i == LAST) begin : g_tail
      // The deepest level refills itself, so repeated pops repeat it.
      assign below = lvl_q[i];
    end else begin : g_link
      assign below = lvl_q[i+1];
    end
    rstk_level #(.ADDR_W(ADDR_W)) u_level (
      .clk          (clk),
      .rst          (rst),
      .op_i         (op),
      .from_above_i (above),
      .from_below_i (below),
      .q_o          (lvl_q[i])
    );
  end

  assign top_o = lvl_q[0];
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic [ADDR_W-1:0] push_addr_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] top_o,
  input logic [ADDR_W-1:0] deep_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (top_o == '0 && deep_q == '0)); // R1

  AST_PUSH_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
    push_i |=> top_o == $past(push_addr_i)); // R2

  AST_PUSH_SHIFTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    push_i |=> deep_q == $past(top_o)); // R3

  AST_POP_RAISES_DEEP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> top_o == $past(deep_q)); // R5

  AST_POP_KEEPS_DEEP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> $stable(deep_q)); // R6

  AST_PUSH_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> top_o == $past(push_addr_i)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> ($stable(top_o) && $stable(deep_q))); // R8
endmodule

bind rstk_top rstk_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .top_o       (top_o),
  .deep_q      (lvl_q[1])
);

// File: tb/rstk_top_tb.sv
`timescale 1ns/1ps
module rstk_top_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [AW-1:0] top;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] m0 = '0;
  logic [AW-1:0] m1 = '0;

  always #2 clk = ~clk;

  rstk_top #(.ADDR_W(AW), .DEPTH(2)) u_dut (
    .clk(clk), .rst(rst), .push_i(push), .push_addr_i(paddr),
    .pop_i(pop), .top_o(top)
  );

  function automatic logic [2*AW-1:0] model_next(logic [AW-1:0] a0, logic [AW-1:0] a1,
                                                 logic ps, logic pp, logic [AW-1:0] ad);
    if (ps)      return {ad, a0};
    else if (pp) return {a1, a1};
    else         return {a0, a1};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: top_o=%h expected %h", req, act, exp);
    end
  endtask

  // Apply one edge: inputs set at negedge, model advanced, output checked at next negedge.
  task automatic step(logic ps, logic pp, logic [AW-1:0] ad, string req);
    logic [2*AW-1:0] nx;
    push = ps; pop = pp; paddr = ad;
    @(posedge clk);
    nx = model_next(m0, m1, ps, pp, ad);
    m0 = nx[2*AW-1:AW];
    m1 = nx[AW-1:0];
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    check(req, top, m0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: top_o=%h expected completion", top);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", top, '0);
    m0 = '0; m1 = '0;

    // R9: upper address bits preserved
    step(1'b1, 1'b0, 12'hF3C, "R2 R9");
    step(1'b1, 1'b0, 12'hA51, "R2");
    step(1'b0, 1'b1, 12'h000, "R3 R5");
    check("R9", top, 12'hF3C);
    // R4: triple push then triple pop
    step(1'b1, 1'b0, 12'h111, "R4");
    step(1'b1, 1'b0, 12'h222, "R4");
    step(1'b1, 1'b0, 12'h333, "R4");
    step(1'b0, 1'b1, 12'h000, "R4");
    check("R4", top, 12'h222);
    step(1'b0, 1'b1, 12'h000, "R4 R6");
    check("R6", top, 12'h222);
    step(1'b0, 1'b1, 12'h000, "R6");
    check("R6", top, 12'h222);
    // R7: simultaneous strobes
    step(1'b1, 1'b1, 12'h9E7, "R7");
    check("R7", top, 12'h9E7);
    // R8: idle cycles preserve both levels
    step(1'b0, 1'b0, 12'hFFF, "R8");
    step(1'b0, 1'b0, 12'h000, "R8");
    step(1'b0, 1'b1, 12'h000, "R8");
    check("R8", top, 12'h222);

    for (int i = 0; i < 3000; i++) begin
      int r;
      logic ps, pp;
      r = int'($urandom_range(0, 9));
      ps = (r < 4) || (r == 9);
      pp = (r >= 4 && r < 8) || (r == 9);
      step(ps, pp, AW'($urandom),
           ps ? (pp ? "R7" : "R2") : (pp ? "R5" : "R8"));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", top, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule